// File: doc/BRIEF.md
# Column-Major 3x3 Neighbourhood Buffer

This block turns a stream of pixels into a stream of complete 3x3 neighbourhoods while reading each pixel only once. The image is walked in horizontal strips of fixed height. Inside a strip, pixels arrive column by column, and each column is scanned from its top row to its bottom row. Two column-deep delay queues hold the two columns before the current one. For each new pixel, three short vertical shift registers pick up the pixel from the same row in each of the three columns, and the rows above come from the previous two cycles.

Once the pipeline is primed, every accepted pixel produces one window a single clock later, so a continuous stream yields one neighbourhood per clock. The upstream side marks the first pixel of each strip with a strip-start flag, and it may insert idle cycles at any point. Windows are emitted only where all nine points lie inside the current strip. Adjacent strips therefore have to overlap by two rows for every output row to be covered.

Top module: `colwin3x3`

## Requirements
- R1: After reset, `win_valid` is low, every `win_data` field is zero, and the first accepted pixel is taken as row 0, column 0 of a strip.
- R2: Field `win_data[(3*k+j)*PIX_W +: PIX_W]` holds the pixel at row r-j of column c-k, where (r,c) is the position of the most recently accepted pixel, for k and j in 0..2.
- R3: A pixel accepted at a rising edge (`pix_valid` high) causes `win_valid` to rise after that same edge, for one cycle, when its window is complete.
- R4: `win_valid` is raised only when the accepted pixel lies in column 2 or later of the strip and in row 2 or later of its column. Each column from the third onward therefore yields STRIP_H-2 windows.
- R5: The row index wraps to 0 after STRIP_H pixels, and the column index then advances. Strips may be any number of columns wide.
- R6: A pixel accepted with `strip_start` high is row 0, column 0 of a new strip. No window is emitted until two more full columns and three pixels of the next column have been accepted.
- R7: A cycle with `pix_valid` low changes no stored state. `win_valid` is low after it, `win_data` holds its value, and the stream continues afterwards as if the idle cycle had not been there.
- R8: With `pix_valid` held high, a strip of N columns produces (N-2)*(STRIP_H-2) windows, and consecutive windows within a column come on consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_valid | input | 1 | Pixel present on `pix_data` this cycle |
| pix_data | input | PIX_W | Incoming pixel value |
| strip_start | input | 1 | Qualified by `pix_valid`: this pixel starts a new strip |
| win_valid | output | 1 | `win_data` holds a complete neighbourhood |
| win_data | output | 9*PIX_W | Nine pixels, newest at field 0, layout per R2 |

## Verification
A queue that delays by the wrong depth, or that shifts during an idle cycle, places a pixel from the wrong row or column in fields 3 to 8. That shows on the first valid window after the fault, and at most one column later. A wrong row or column count moves the edges of the `win_valid` bursts within one column, and a missing flush shows as a window emitted too early after `strip_start`. The bench compares every field of every window against a behavioural image store, and it checks the count and the placement of the windows across strips, idle cycles and an aborted strip.

// File: rtl/colwin_pkg.sv
package colwin_pkg;
   localparam int WIN_SIDE = 3;
   localparam int WIN_PTS  = WIN_SIDE * WIN_SIDE;
   localparam int COL_CAP  = WIN_SIDE - 1;
endpackage

// File: rtl/colwin_delay_queue.sv
module colwin_delay_queue #(
   parameter int W     = 8,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] din,
   output logic [W-1:0] oldest
);
   initial begin
      if (DEPTH < 1) $error("DEPTH must be at least 1");
   end

   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (en) begin
         mem[0] <= din;
         for (int i = 1; i < DEPTH; i++) mem[i] <= mem[i-1];
      end
   end

   assign oldest = mem[DEPTH-1];

   // R7: an idle cycle leaves the queue untouched
   a_r7_queue_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(oldest));
endmodule

// File: rtl/colwin_column_taps.sv
module colwin_column_taps #(
   parameter int W   = 8,
   parameter int LEN = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         clr,
   input  logic [W-1:0] din,
   output logic [W-1:0] tap [LEN]
);
   initial begin
      if (LEN < 2) $error("LEN must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < LEN; i++) tap[i] <= '0;
      end else if (en) begin
         tap[0] <= din;
         for (int i = 1; i < LEN; i++) tap[i] <= clr ? '0 : tap[i-1];
      end
   end

   // R2: the row above is the previous newest value
   a_r2_vertical_shift: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr) |=> tap[1] == $past(tap[0]));
endmodule

// File: rtl/colwin_pos_track.sv
module colwin_pos_track #(
   parameter int STRIP_H = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic accept,
   input  logic start,
   output logic win_ok
);
   import colwin_pkg::*;
   localparam int ROW_W = (STRIP_H > 1) ? $clog2(STRIP_H) : 1;
   localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(STRIP_H - 1);
   localparam logic [ROW_W-1:0] ROW_MIN  = ROW_W'(WIN_SIDE - 1);

   logic [ROW_W-1:0] row_q, cur_row;
   logic [1:0]       col_q, cur_col;

   assign cur_row = start ? '0 : row_q;
   assign cur_col = start ? '0 : col_q;
   assign win_ok  = (cur_col == 2'(COL_CAP)) && (cur_row >= ROW_MIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q <= '0;
         col_q <= '0;
      end else if (accept) begin
         if (cur_row == ROW_LAST) begin
            row_q <= '0;
            col_q <= (cur_col == 2'(COL_CAP)) ? cur_col : cur_col + 2'd1;
         end else begin
            row_q <= cur_row + 1'b1;
            col_q <= cur_col;
         end
      end
   end

   // R5: row index stays inside the strip
   a_r5_row_range: assert property (@(posedge clk) disable iff (!rst_n)
      row_q <= ROW_LAST);
   // R5: column count saturates
   a_r5_col_sat: assert property (@(posedge clk) disable iff (!rst_n)
      col_q <= 2'(COL_CAP));
endmodule

// File: rtl/colwin3x3.sv
module colwin3x3 #(
   parameter int PIX_W   = 8,
   parameter int STRIP_H = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pix_valid,
   input  logic [PIX_W-1:0]   pix_data,
   input  logic               strip_start,
   output logic               win_valid,
   output logic [9*PIX_W-1:0] win_data
);
   import colwin_pkg::*;

   initial begin
      if (PIX_W < 1)   $error("PIX_W must be positive");
      if (STRIP_H < 3) $error("STRIP_H must cover the window height");
   end

   logic             accept, win_ok;
   logic [PIX_W-1:0] col_in [WIN_SIDE];
   logic [PIX_W-1:0] taps   [WIN_SIDE][WIN_SIDE];

   assign accept    = pix_valid;
   assign col_in[0] = pix_data;

   colwin_pos_track #(.STRIP_H(STRIP_H)) u_pos (
      .clk(clk), .rst_n(rst_n), .accept(accept),
      .start(strip_start), .win_ok(win_ok));

   for (genvar q = 0; q < WIN_SIDE - 1; q++) begin : g_queue
      colwin_delay_queue #(.W(PIX_W), .DEPTH(STRIP_H)) u_q (
         .clk(clk), .rst_n(rst_n), .en(accept),
         .din(col_in[q]), .oldest(col_in[q+1]));
   end

   for (genvar k = 0; k < WIN_SIDE; k++) begin : g_col
      colwin_column_taps #(.W(PIX_W), .LEN(WIN_SIDE)) u_taps (
         .clk(clk), .rst_n(rst_n), .en(accept), .clr(strip_start),
         .din(col_in[k]), .tap(taps[k]));
      for (genvar j = 0; j < WIN_SIDE; j++) begin : g_row
         assign win_data[(k*WIN_SIDE+j)*PIX_W +: PIX_W] = taps[k][j];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) win_valid <= 1'b0;
      else        win_valid <= accept && win_ok;
   end

   // R3: a window follows an accepted pixel
   a_r3_valid_needs_pixel: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> $past(pix_valid));
   // R7: idle cycle holds the window
   a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |=> (!win_valid && $stable(win_data)));
   // R6: strip start never completes a window
   a_r6_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && strip_start) |=> !win_valid);
endmodule

// File: tb/tb_colwin3x3.sv
module tb_colwin3x3;
   localparam int CLK_PERIOD = 10;
   localparam int W = 8;
   localparam int H = 16;

   logic clk = 0, rst_n = 0;
   logic pix_valid = 0, strip_start = 0;
   logic [W-1:0] pix_data = '0;
   logic win_valid;
   logic [9*W-1:0] win_data;

   colwin3x3 #(.PIX_W(W), .STRIP_H(H)) dut (
      .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
      .strip_start(strip_start), .win_valid(win_valid), .win_data(win_data));

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, errors = 0;
   bit finished = 0;
   logic [W-1:0] img [0:63][0:H-1];
   int m_row = 0, m_col = 0;
   bit exp_valid = 0, last_idle = 0, have_prev = 0;
   logic [9*W-1:0] exp_win = '0, prev_win = '0;
   int win_count = 0;

   task automatic chk(bit ok, string req, logic [9*W-1:0] act, logic [9*W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // compare the outputs produced by the previous drive, then drive next input
   task automatic step(bit v, bit s, logic [W-1:0] d);
      @(negedge clk);
      chk(win_valid == exp_valid, "R3/R4 win_valid", 72'(win_valid), 72'(exp_valid));
      if (exp_valid) begin
         chk(win_data == exp_win, "R2 window content", win_data, exp_win);
         win_count++;
      end
      if (last_idle && have_prev)
         chk(win_data == prev_win, "R7 window held while idle", win_data, prev_win);
      prev_win = win_data; have_prev = 1;
      pix_valid = v; strip_start = s; pix_data = d;
      last_idle = !v;
      exp_valid = 0;
      if (v) begin
         if (s) begin m_row = 0; m_col = 0; end
         img[m_col][m_row] = d;
         if (m_col >= 2 && m_row >= 2) begin
            exp_valid = 1;
            for (int k = 0; k < 3; k++)
               for (int j = 0; j < 3; j++)
                  exp_win[(k*3+j)*W +: W] = img[m_col-k][m_row-j];
         end
         m_row++;
         if (m_row == H) begin m_row = 0; m_col++; end
      end
   endtask

   task automatic run_strip(int ncols, int idle_pct, bit first_start);
      for (int p = 0; p < ncols*H; p++) begin
         while (idle_pct > 0 && ($urandom % 100) < idle_pct) step(0, 0, W'($urandom));
         step(1, (p == 0) && first_start, W'($urandom));
      end
   endtask

   initial begin
      #(CLK_PERIOD*100000);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int streak, best;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(win_valid == 0, "R1 reset valid", 72'(win_valid), 72'(0));
      chk(win_data == '0, "R1 reset window", win_data, '0);
      rst_n = 1;
      // R1/R5/R8: first strip without start flag, continuous, 5 columns
      win_count = 0;
      run_strip(5, 0, 0);
      step(0, 0, '0);
      chk(win_count == 3*(H-2), "R8 window count continuous", 72'(win_count), 72'(3*(H-2)));
      // R8: windows on consecutive clocks within a column
      streak = 0; best = 0;
      for (int p = 0; p < 3*H; p++) begin
         step(1, p == 0, W'($urandom));
         @(posedge clk); #1;
      end
      step(0, 0, '0);
      for (int p = 0; p < 3*H; p++) begin
         step(1, p == 0, W'(p));
         if (exp_valid) streak++; else begin if (streak > best) best = streak; streak = 0; end
      end
      step(0, 0, '0);
      if (streak > best) best = streak;
      chk(best == H-2, "R8 consecutive windows", 72'(best), 72'(H-2));
      // R6/R7: new strip with idle cycles
      win_count = 0;
      run_strip(4, 30, 1);
      step(0, 0, '0);
      chk(win_count == 2*(H-2), "R6 windows after strip start", 72'(win_count), 72'(2*(H-2)));
      // R6: abort a strip mid-column, restart
      run_strip(1, 0, 1);
      for (int p = 0; p < 5; p++) step(1, 0, W'($urandom));
      win_count = 0;
      run_strip(3, 10, 1);
      step(0, 0, '0);
      chk(win_count == H-2, "R6 flush after aborted strip", 72'(win_count), 72'(H-2));
      step(0, 0, '0);
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule